// File: doc/BRIEF.md
# First-Level Compressed Prefix Lookup

This block resolves the first level of a longest-prefix route search for a 32-bit IPv4 destination. The upper 16 address bits name one position in a 64K-bit presence vector. That vector is never stored directly. It is held in compressed form: one 16-bit code word for each 16-bit slice of the vector, one 16-bit running count of set bits for each group of four slices, and a table of small within-group offsets. Each row of that table is one possible slice pattern. Together these select one entry of a pointer array, and that entry is the answer.

A code word packs a 10-bit row number (upper bits) and a 6-bit offset (lower bits). If the row number is above 676, the code word does not name a row. It is then returned unchanged as the pointer, and neither the offset table nor the pointer array is read. Every pointer is 16 bits. Its two top bits give the pointer type and its low 14 bits index either the next-hop table or a second-level chunk.

Each of the three reads is one pipeline stage: code word and count first, offset table second, pointer array third. A new address can be accepted on every clock. A host write port with one enable per RAM loads the four tables while no lookups are in flight.

Top module: `lpm_l1_lookup`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, res_valid is 0. A reset in the middle of lookups discards those results.
- R2: A request taken at rising edge n makes res_valid 1 in the cycle after edge n+2. A cycle with lk_valid low yields no result 3 edges later.
- R3: Requests on consecutive cycles each give one result, in issue order and on consecutive cycles.
- R4: The code word is read at index lk_addr[31:20] and the group count at index lk_addr[31:22]. Bits [15:0] of the address have no effect.
- R5: The column is lk_addr[19:16]. The offset table is read at (row*16 + column), taken modulo its depth.
- R6: For a row of 676 or less, res_ptr = pointer_array[count + code-word offset + table offset], with the index taken modulo the pointer array depth.
- R7: For a row above 676 (677 included), res_ptr equals the 16-bit code word, whatever the other tables hold.
- R8: Write enable bit 0 writes a code word, bit 1 a group count, bit 2 an offset-table entry (wr_data[3:0]), and bit 3 a pointer. Each write goes to index wr_addr. No write is made while lookups are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Destination address |
| wr_en | input | 4 | Table write enables: code word, count, offset table, pointer |
| wr_addr | input | 12 | Table write index |
| wr_data | input | 16 | Table write data |
| res_valid | output | 1 | Result strobe |
| res_ptr | output | 16 | Type (bits 15:14) and index (bits 13:0) |

## Verification
A wrong stage-valid bit shows up three edges after the request as a missing, extra or shifted res_valid. Back-to-back streams expose this at once, as a gap or a reordering. A wrong code-word split, column slice or sum gives a pointer from the wrong array slot. The bench fills each slot it relies on with a distinct value and leaves nearby slots unwritten, so such a slip is seen in the first result that uses it. A misplaced direct threshold is caught on the 676 and 677 rows. There the result is either the raw code word or an array entry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int PTR_W      = 16;
  localparam int ROW_W      = 10;
  localparam int CWOFF_W    = 6;
  localparam int MOFF_W     = 4;
  localparam int COL_W      = 4;
  localparam int DIRECT_MIN = 677;

  typedef struct packed {
    logic [ROW_W-1:0]   row;
    logic [CWOFF_W-1:0] off;
  } codeword_t;

  localparam int WE_CW   = 0;
  localparam int WE_BASE = 1;
  localparam int WE_MAP  = 2;
  localparam int WE_PTR  = 3;
endpackage

// File: rtl/lpm_sram.sv
module lpm_sram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lpm_cw_decode.sv
module lpm_cw_decode
  import lpm_pkg::*;
#(
  parameter int MAP_AW = 10
) (
  input  codeword_t          cw,
  input  logic [COL_W-1:0]   col,
  output logic [MAP_AW-1:0]  map_addr,
  output logic               direct,
  output logic [CWOFF_W-1:0] cw_off
);
  logic [ROW_W+COL_W-1:0] full_addr;

  always_comb begin
    full_addr = {cw.row, col};
    map_addr  = full_addr[MAP_AW-1:0];
    direct    = (32'(cw.row) >= DIRECT_MIN);
    cw_off    = cw.off;
  end
endmodule

// File: rtl/lpm_l1_lookup.sv
module lpm_l1_lookup
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 16,
  parameter int MAP_AW = 10,
  parameter int PTR_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [3:0]        wr_en,
  input  logic [11:0]       wr_addr,
  input  logic [PTR_W-1:0]  wr_data,
  output logic              res_valid,
  output logic [PTR_W-1:0]  res_ptr
);
  localparam int CW_AW   = VEC_W - COL_W;
  localparam int BASE_AW = CW_AW - 2;
  localparam int COL_LSB = ADDR_W - VEC_W;

  // stage 1 read addresses
  logic [CW_AW-1:0]   cw_raddr;
  logic [BASE_AW-1:0] base_raddr;
  logic [COL_W-1:0]   col_in;
  logic [PTR_W-1:0]   cw_q;
  logic [PTR_W-1:0]   base_q;
  logic [MOFF_W-1:0]  map_q;
  logic [PTR_W-1:0]   ptr_q;

  // pipeline registers and next values
  logic               s1_valid, s1_valid_d;
  logic [COL_W-1:0]   s1_col,   s1_col_d;
  logic               s2_valid, s2_valid_d;
  logic [PTR_W-1:0]   s2_sum,   s2_sum_d;
  logic               s2_direct, s2_direct_d;
  logic [PTR_W-1:0]   s2_cw,    s2_cw_d;
  logic               s3_valid, s3_valid_d;
  logic               s3_direct, s3_direct_d;
  logic [PTR_W-1:0]   s3_cw,    s3_cw_d;

  logic [MAP_AW-1:0]  map_raddr;
  logic               dec_direct;
  logic [CWOFF_W-1:0] dec_off;
  logic [PTR_W-1:0]   ptr_index;

  assign cw_raddr   = lk_addr[ADDR_W-1 -: CW_AW];
  assign base_raddr = lk_addr[ADDR_W-1 -: BASE_AW];
  assign col_in     = lk_addr[COL_LSB +: COL_W];

  lpm_sram #(.AW(CW_AW), .DW(PTR_W)) u_cw_ram (
    .clk(clk), .we(wr_en[WE_CW]), .waddr(wr_addr[CW_AW-1:0]), .wdata(wr_data),
    .re(lk_valid), .raddr(cw_raddr), .rdata(cw_q)
  );

  lpm_sram #(.AW(BASE_AW), .DW(PTR_W)) u_base_ram (
    .clk(clk), .we(wr_en[WE_BASE]), .waddr(wr_addr[BASE_AW-1:0]), .wdata(wr_data),
    .re(lk_valid), .raddr(base_raddr), .rdata(base_q)
  );

  lpm_cw_decode #(.MAP_AW(MAP_AW)) u_decode (
    .cw(codeword_t'(cw_q)), .col(s1_col), .map_addr(map_raddr),
    .direct(dec_direct), .cw_off(dec_off)
  );

  lpm_sram #(.AW(MAP_AW), .DW(MOFF_W)) u_map_ram (
    .clk(clk), .we(wr_en[WE_MAP]), .waddr(wr_addr[MAP_AW-1:0]),
    .wdata(wr_data[MOFF_W-1:0]), .re(s1_valid), .raddr(map_raddr), .rdata(map_q)
  );

  assign ptr_index = s2_sum + PTR_W'(map_q);

  lpm_sram #(.AW(PTR_AW), .DW(PTR_W)) u_ptr_ram (
    .clk(clk), .we(wr_en[WE_PTR]), .waddr(wr_addr[PTR_AW-1:0]), .wdata(wr_data),
    .re(s2_valid), .raddr(ptr_index[PTR_AW-1:0]), .rdata(ptr_q)
  );

  // next-state logic
  always_comb begin
    s1_valid_d  = lk_valid;
    s1_col_d    = col_in;
    s2_valid_d  = s1_valid;
    s2_sum_d    = base_q + PTR_W'(dec_off);
    s2_direct_d = dec_direct;
    s2_cw_d     = cw_q;
    s3_valid_d  = s2_valid;
    s3_direct_d = s2_direct;
    s3_cw_d     = s2_cw;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s3_valid <= 1'b0;
    end else begin
      s1_valid <= s1_valid_d;
      s2_valid <= s2_valid_d;
      s3_valid <= s3_valid_d;
    end
  end

  // data registers, loaded only with a live request
  always_ff @(posedge clk) begin
    if (lk_valid) s1_col <= s1_col_d;
    if (s1_valid) begin
      s2_sum    <= s2_sum_d;
      s2_direct <= s2_direct_d;
      s2_cw     <= s2_cw_d;
    end
    if (s2_valid) begin
      s3_direct <= s3_direct_d;
      s3_cw     <= s3_cw_d;
    end
  end

  assign res_valid = s3_valid;
  assign res_ptr   = s3_direct ? s3_cw : ptr_q;
endmodule

// File: rtl/lpm_l1_checker.sv
module lpm_l1_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [3:0]  wr_en,
  input logic        res_valid,
  input logic [15:0] res_ptr,
  input logic        s1_valid,
  input logic [15:0] cw_rd
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !res_valid);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ##3 res_valid);

  p_no_phantom_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> ##3 !res_valid);

  p_direct_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && cw_rd[15:6] > 10'd676) |-> ##2 (res_valid && res_ptr == $past(cw_rd, 2)));

  p_write_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != 4'b0) |-> !lk_valid);
endmodule

bind lpm_l1_lookup lpm_l1_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .wr_en(wr_en),
  .res_valid(res_valid), .res_ptr(res_ptr), .s1_valid(s1_valid), .cw_rd(cw_q)
);

// File: tb/sim_lpm_l1_lookup.sv
`timescale 1ns/1ps
module sim_lpm_l1_lookup;
  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic [3:0]  wr_en;
  logic [11:0] wr_addr;
  logic [15:0] wr_data;
  logic        res_valid;
  logic [15:0] res_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lpm_l1_lookup u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .res_valid(res_valid), .res_ptr(res_ptr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {address, expected pointer}; table contents loaded below
  localparam logic [47:0] VEC [6] = '{
    {32'h1234_ABCD, 16'h4111},  // count 100 + off 3 + map 7 -> slot 110
    {32'h123F_0000, 16'hC222},  // column 15: 100 + 3 + 15 -> slot 118
    {32'h1201_FFFF, 16'h0333},  // same group: 100 + 0 + 2 -> slot 102
    {32'hABC5_1111, 16'hAF09},  // row 700 -> code word itself
    {32'h7FF2_0000, 16'h8444},  // row 676: 200 + 1 + 5 -> slot 206
    {32'h7FE0_0000, 16'hA940}   // row 677 -> code word itself
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 4'(1 << sel); wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 4'b0;
  endtask

  // single request, verify the result cycle exactly
  task automatic lookup(input string req, input logic [31:0] a, input logic [15:0] exp);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0; lk_addr = '0;
    check({req, " R2 early"}, 32'(res_valid), 32'd0);
    @(negedge clk);
    check({req, " R2 early"}, 32'(res_valid), 32'd0);
    @(negedge clk);
    check({req, " R2 valid"}, 32'(res_valid), 32'd1);
    check(req, 32'(res_ptr), 32'(exp));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0;
    wr_en = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(res_valid), 32'd0);

    // R8: load tables (bit0 code word, bit1 count, bit2 offset table, bit3 pointer)
    wr(0, 12'h123, 16'h0143);   // row 5, off 3
    wr(0, 12'h120, 16'h0080);   // row 2, off 0
    wr(0, 12'hABC, 16'hAF09);   // row 700, direct
    wr(0, 12'h7FF, 16'hA901);   // row 676, off 1
    wr(0, 12'h7FE, 16'hA940);   // row 677, direct
    wr(1, 12'h048, 16'd100);
    wr(1, 12'h1FF, 16'd200);
    wr(2, 12'd84,  16'd7);      // row 5 col 4
    wr(2, 12'd95,  16'd15);     // row 5 col 15
    wr(2, 12'd33,  16'd2);      // row 2 col 1
    wr(2, 12'd578, 16'd5);      // (676*16+2) mod 1024
    wr(3, 12'd110, 16'h4111);
    wr(3, 12'd118, 16'hC222);
    wr(3, 12'd102, 16'h0333);
    wr(3, 12'd206, 16'h8444);

    // R4 R5 R6 R7: table-driven single lookups
    for (int i = 0; i < 6; i++) begin
      lookup((i == 3 || i == 5) ? "R7 direct" : "R6 R5 R4 indexed",
             VEC[i][47:16], VEC[i][15:0]);
    end

    // R3: back-to-back stream
    begin
      int got = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (res_valid) begin
          if (got < 6) check("R3 stream order", 32'(res_ptr), 32'(VEC[got][15:0]));
          got++;
        end
        if (c >= 3 && c < 9) check("R3 consecutive", 32'(res_valid), 32'd1);
        lk_valid = (c < 6);
        lk_addr  = (c < 6) ? VEC[c][47:16] : 32'h0;
      end
      check("R3 result count", 32'(got), 32'd6);
    end

    // R8: rewrite one offset entry and one pointer, then look up again
    wr(2, 12'd84, 16'd9);
    wr(3, 12'd112, 16'h1555);
    lookup("R8 rewrite", 32'h1234_0000, 16'h1555);

    // R1: reset while a request is in flight drops it
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h123F_0000;
    @(negedge clk);
    lk_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flushed", 32'(res_valid), 32'd0);
    @(negedge clk);
    check("R1 flushed", 32'(res_valid), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule